// File: doc/BRIEF.md
# Indirect Host Register Port with Start-Up Control

This block is the byte-wide host port of a video encoder. The host puts an address byte on the shared data bus and then reads or writes data at that address. It can reach either a bank of 8-bit control registers or a colour lookup table whose entries hold three bytes each. A 2-bit select input chooses between loading the address, accessing a control register and accessing a lookup-table byte. Every data access moves the relevant index forward, so a burst of accesses walks through successive locations without reloading the address.

The block also decides when the encoder starts. While the reset pin is low, the host logic is held in its initial state, the software run bit is cleared, and the power-down flag is raised. The stored register and table contents survive both reset and power-down.

On release, behaviour depends on the hardware-start bit. If it is set, the encoder starts by itself once reset is released. If it is clear, the encoder waits until the host sets the software run bit. Each start is signalled by a one-clock pulse that the video timing logic uses to begin line 1 of field 1. Two registers hold an extended configuration word, which only reaches its output when a gate bit enables it.

Top module: `hostreg_port`

## Requirements
- R1: The select input encodes 00 as the address slot, 01 as control register, 10 as lookup table and 11 as reserved. A write to the address slot loads the byte. The low bits of that byte become both the register index and the table index. A read of the address slot returns the last loaded byte.
- R2: Each control-register read or write uses the current register index and then advances it by one. The index wraps from NUM_CREGS-1 to 0.
- R3: A table entry takes three byte accesses, in the order red, green, blue. The table index advances only after the blue byte and wraps from LUT_DEPTH-1 to 0.
- R4: Loading a new address returns the byte position to red.
- R5: A read of the reserved select returns 0x00. A write to it changes no stored value and no index.
- R6: One access happens per assertion of the strobe (select high with read or write high), on the first clock edge at which it is seen. Holding the strobe does not repeat the access. Read data appears after that edge and stays stable for as long as the strobe is held.
- R7: While reset is held, the power-down flag is high, the start pulse is low, and the data output and address are 0x00.
- R8: Control-register contents and table contents are kept through power-down and through the reset pin. The only exception is the software run bit (register 0, bit 0), which reset clears.
- R9: When the hardware-start bit (register 0, bit 1) is 1, the start pulse rises on the third rising clock edge after the reset pin goes high. The power-down flag falls at the same time. In this mode, changes to the software run bit have no effect.
- R10: When the hardware-start bit is 0, the block stays powered down until the software run bit goes from 0 to 1. The start pulse then appears on the edge after the write. Writing 1 again gives no further pulse. Clearing the bit raises the power-down flag again.
- R11: The start pulse lasts exactly one clock, and the power-down flag is low while the pulse is high.
- R12: The extended configuration output is {register 15, register 14 bits 6..0} when register 14 bit 7 is 1. It is all zeros when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset pin, released through a two-stage synchroniser |
| sel_i | input | 1 | Host chip select, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high; takes priority over read |
| adr_i | input | 2 | Access select: address, control register, table, reserved |
| din_i | input | 8 | Host write data |
| dout_o | output | 8 | Host read data |
| start_o | output | 1 | One-clock pulse that begins line 1 of field 1 |
| pwrdn_o | output | 1 | Encoder power-down flag |
| ext_cfg_o | output | 15 | Gated extended configuration word |

## Verification
The bench builds the block with NUM_CREGS=16 and LUT_DEPTH=16. With these values, the register index wraps from 15 to 0 and the table index wraps from entry 15 to entry 0 within a few accesses. The register holding the extended-configuration gate bit is the second-to-last register at this size, so the gate test and the register wrap test exercise the same region. The small table also lets the bench fill the last entry and the first entry and read back across the wrap in one short run.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
  localparam int unsigned HB_W       = 8;
  localparam int unsigned LANES      = 3;
  localparam int unsigned RUN_BIT    = 0;
  localparam int unsigned HWST_BIT   = 1;
  localparam int unsigned EXT_LO_REG = 14;
  localparam int unsigned EXT_HI_REG = 15;
  localparam int unsigned EXT_EN_BIT = 7;
  localparam int unsigned EXT_W      = 2 * HB_W - 1;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_CREG = 2'b01,
    SEL_LUT  = 2'b10,
    SEL_RSVD = 2'b11
  } hsel_e;
endpackage

// File: rtl/hostreg_front.sv
module hostreg_front
  import hostreg_pkg::*;
#(
  parameter int unsigned CIDX_W = 4,
  parameter int unsigned LIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        adr_i,
  input  logic [HB_W-1:0]   din_i,
  input  logic [HB_W-1:0]   creg_rdata_i,
  input  logic [HB_W-1:0]   lut_rdata_i,
  output logic              creg_we_o,
  output logic [CIDX_W-1:0] creg_idx_o,
  output logic              lut_we_o,
  output logic [LIDX_W-1:0] lut_idx_o,
  output logic [1:0]        lut_lane_o,
  output logic [HB_W-1:0]   dout_o
);
  localparam logic [1:0] LANE_LAST = 2'(LANES - 1);

  logic              acc_q;
  logic [HB_W-1:0]   addr_q, addr_d;
  logic [CIDX_W-1:0] cidx_q, cidx_d;
  logic [LIDX_W-1:0] lidx_q, lidx_d;
  logic [1:0]        lane_q, lane_d;
  logic [HB_W-1:0]   dout_q, dout_d;
  logic              acc, fire, is_wr, is_rd;
  hsel_e             sel_c;

  // next-state logic
  always_comb begin
    acc    = sel_i & (rd_i | wr_i);
    fire   = acc & ~acc_q;
    is_wr  = fire & wr_i;
    is_rd  = fire & ~wr_i;
    sel_c  = hsel_e'(adr_i);
    addr_d = addr_q;
    cidx_d = cidx_q;
    lidx_d = lidx_q;
    lane_d = lane_q;
    dout_d = dout_q;
    creg_we_o = 1'b0;
    lut_we_o  = 1'b0;
    unique case (sel_c)
      SEL_ADDR: begin
        if (is_wr) begin
          addr_d = din_i;
          cidx_d = din_i[CIDX_W-1:0];
          lidx_d = din_i[LIDX_W-1:0];
          lane_d = 2'd0;
        end
        if (is_rd) dout_d = addr_q;
      end
      SEL_CREG: begin
        creg_we_o = is_wr;
        if (is_rd) dout_d = creg_rdata_i;
        if (fire)  cidx_d = cidx_q + 1'b1;
      end
      SEL_LUT: begin
        lut_we_o = is_wr;
        if (is_rd) dout_d = lut_rdata_i;
        if (fire) begin
          if (lane_q == LANE_LAST) begin
            lane_d = 2'd0;
            lidx_d = lidx_q + 1'b1;
          end else begin
            lane_d = lane_q + 2'd1;
          end
        end
      end
      SEL_RSVD: begin
        if (is_rd) dout_d = '0;
      end
      default: ;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      addr_q <= '0;
      cidx_q <= '0;
      lidx_q <= '0;
      lane_q <= '0;
      dout_q <= '0;
    end else begin
      acc_q  <= acc;
      addr_q <= addr_d;
      cidx_q <= cidx_d;
      lidx_q <= lidx_d;
      lane_q <= lane_d;
      dout_q <= dout_d;
    end
  end

  assign creg_idx_o = cidx_q;
  assign lut_idx_o  = lidx_q;
  assign lut_lane_o = lane_q;
  assign dout_o     = dout_q;
endmodule

// File: rtl/hostreg_cregs.sv
module hostreg_cregs
  import hostreg_pkg::*;
#(
  parameter int unsigned NUM_CREGS = 16,
  parameter int unsigned CIDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CIDX_W-1:0] idx_i,
  input  logic [HB_W-1:0]   wdata_i,
  output logic [HB_W-1:0]   rdata_o,
  output logic              run_bit_o,
  output logic              hwst_bit_o,
  output logic [EXT_W-1:0]  ext_cfg_o
);
  logic [HB_W-1:0] mem_q [NUM_CREGS];
  logic            run_q, run_d;
  logic            hit0;

  // storage without reset: contents survive reset and power-down
  for (genvar g = 0; g < NUM_CREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we_i && (idx_i == CIDX_W'(g))) mem_q[g] <= wdata_i;
    end
  end

  // software run bit is the only stored bit cleared by reset
  always_comb begin
    hit0  = we_i && (idx_i == '0);
    run_d = hit0 ? wdata_i[RUN_BIT] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  always_comb begin
    rdata_o = mem_q[idx_i];
    if (idx_i == '0) rdata_o[RUN_BIT] = run_q;
  end

  assign run_bit_o  = run_q;
  assign hwst_bit_o = mem_q[0][HWST_BIT];
  assign ext_cfg_o  = mem_q[EXT_LO_REG][EXT_EN_BIT]
                    ? {mem_q[EXT_HI_REG], mem_q[EXT_LO_REG][HB_W-2:0]}
                    : '0;
endmodule

// File: rtl/hostreg_lut.sv
module hostreg_lut
  import hostreg_pkg::*;
#(
  parameter int unsigned LUT_DEPTH = 256,
  parameter int unsigned LIDX_W    = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [LIDX_W-1:0] idx_i,
  input  logic [1:0]        lane_i,
  input  logic [HB_W-1:0]   wdata_i,
  output logic [HB_W-1:0]   rdata_o
);
  logic [HB_W-1:0] lane_rd [LANES];

  // one storage array per colour component
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [HB_W-1:0] mem [LUT_DEPTH];
    always_ff @(posedge clk) begin
      if (we_i && (lane_i == 2'(l))) mem[idx_i] <= wdata_i;
    end
    assign lane_rd[l] = mem[idx_i];
  end

  always_comb begin
    rdata_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_i == 2'(l)) rdata_o = lane_rd[l];
    end
  end
endmodule

// File: rtl/hostreg_start.sv
module hostreg_start (
  input  logic clk,
  input  logic rst_n,
  input  logic run_bit_i,
  input  logic hwst_i,
  output logic start_o,
  output logic pwrdn_o
);
  logic boot_q, boot_d;
  logic prev_q, prev_d;
  logic run_q, run_d;
  logic start_q, start_d;

  // next-state logic
  always_comb begin
    start_d = 1'b0;
    if (hwst_i) begin
      if (!boot_q) start_d = 1'b1;
    end else if (run_bit_i && !prev_q) begin
      start_d = 1'b1;
    end
    run_d = run_q;
    if (start_d)                    run_d = 1'b1;
    else if (!hwst_i && !run_bit_i) run_d = 1'b0;
    boot_d = 1'b1;
    prev_d = run_bit_i;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= 1'b0;
      prev_q  <= 1'b0;
      run_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      boot_q  <= boot_d;
      prev_q  <= prev_d;
      run_q   <= run_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;
  assign pwrdn_o = ~run_q;
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
  import hostreg_pkg::*;
#(
  parameter int unsigned NUM_CREGS = 16,
  parameter int unsigned LUT_DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [1:0]       adr_i,
  input  logic [HB_W-1:0]  din_i,
  output logic [HB_W-1:0]  dout_o,
  output logic             start_o,
  output logic             pwrdn_o,
  output logic [EXT_W-1:0] ext_cfg_o
);
  localparam int unsigned CIDX_W = $clog2(NUM_CREGS);
  localparam int unsigned LIDX_W = $clog2(LUT_DEPTH);

  logic [SYNC_DEPTH-1:0] rsync_q;
  logic                  rst_int_n;
  logic                  creg_we, lut_we;
  logic [CIDX_W-1:0]     creg_idx;
  logic [LIDX_W-1:0]     lut_idx;
  logic [1:0]            lut_lane;
  logic [HB_W-1:0]       creg_rdata, lut_rdata;
  logic                  run_bit, hwst_bit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_int_n = rsync_q[SYNC_DEPTH-1];

  hostreg_front #(.CIDX_W(CIDX_W), .LIDX_W(LIDX_W)) u_front (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sel_i        (sel_i),
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .adr_i        (adr_i),
    .din_i        (din_i),
    .creg_rdata_i (creg_rdata),
    .lut_rdata_i  (lut_rdata),
    .creg_we_o    (creg_we),
    .creg_idx_o   (creg_idx),
    .lut_we_o     (lut_we),
    .lut_idx_o    (lut_idx),
    .lut_lane_o   (lut_lane),
    .dout_o       (dout_o)
  );

  hostreg_cregs #(.NUM_CREGS(NUM_CREGS), .CIDX_W(CIDX_W)) u_cregs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we_i       (creg_we),
    .idx_i      (creg_idx),
    .wdata_i    (din_i),
    .rdata_o    (creg_rdata),
    .run_bit_o  (run_bit),
    .hwst_bit_o (hwst_bit),
    .ext_cfg_o  (ext_cfg_o)
  );

  hostreg_lut #(.LUT_DEPTH(LUT_DEPTH), .LIDX_W(LIDX_W)) u_lut (
    .clk     (clk),
    .we_i    (lut_we),
    .idx_i   (lut_idx),
    .lane_i  (lut_lane),
    .wdata_i (din_i),
    .rdata_o (lut_rdata)
  );

  hostreg_start u_start (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run_bit_i (run_bit),
    .hwst_i    (hwst_bit),
    .start_o   (start_o),
    .pwrdn_o   (pwrdn_o)
  );
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk (
  input logic       clk,
  input logic       rst_int_n,
  input logic       sel_i,
  input logic       rd_i,
  input logic       wr_i,
  input logic [1:0] adr_i,
  input logic [7:0] dout_o,
  input logic       start_o,
  input logic       pwrdn_o
);
  // R7: outputs held in their reset state
  a_r7_reset_state: assert property (@(posedge clk)
    !rst_int_n |-> (pwrdn_o && !start_o && dout_o == 8'h00));

  // R11: pulse is one clock wide
  a_r11_one_clock_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_o |=> !start_o);

  // R11: powered up during the pulse
  a_r11_powered_on_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_o |-> !pwrdn_o);

  // R9 / R10: leaving power-down only together with a start pulse
  a_r9_wake_with_start: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(pwrdn_o) |-> start_o);

  // R5: reserved read returns zero
  a_r5_rsvd_read_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_i && rd_i && !wr_i && adr_i == 2'b11 && !$past(sel_i && (rd_i || wr_i)))
    |=> dout_o == 8'h00);

  // R6: held read strobe keeps data stable
  a_r6_read_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_i && rd_i && !wr_i && $past(sel_i && rd_i && !wr_i)) |=> $stable(dout_o));
endmodule

bind hostreg_port hostreg_port_chk u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .sel_i     (sel_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .adr_i     (adr_i),
  .dout_o    (dout_o),
  .start_o   (start_o),
  .pwrdn_o   (pwrdn_o)
);

// File: tb/hostreg_port_tb_top.sv
module hostreg_port_tb_top;
  localparam int unsigned NC = 16;
  localparam int unsigned LD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  adr = 2'b00;
  logic [7:0]  din = 8'h00;
  logic [7:0]  dout;
  logic        start, pwrdn;
  logic [14:0] ext;

  int total = 0;
  int bad = 0;
  int pulses = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  hostreg_port #(.NUM_CREGS(NC), .LUT_DEPTH(LD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .adr_i(adr), .din_i(din), .dout_o(dout), .start_o(start),
    .pwrdn_o(pwrdn), .ext_cfg_o(ext)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: write, strobe held across two edges
  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b1; adr = a; din = d;
    @(posedge clk); @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  // driver: read, pushes the expected byte to the scoreboard
  task automatic hrd(input logic [1:0] a, input logic [7:0] e, input string t);
    exp_t item;
    item.val = e; item.tag = t;
    sb.push_back(item);
    @(posedge clk); #1;
    sel = 1'b1; rd = 1'b1; adr = a;
    repeat (3) @(posedge clk);
    #1;
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic exp_start);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 pwrdn in reset", pwrdn, 1);
    check("R7 start in reset", start, 0);
    check("R7 dout in reset", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 no pulse after edge 1", start, 0);
    @(negedge clk);
    check("R9 no pulse after edge 2", start, 0);
    @(negedge clk);
    check("R9 pulse after edge 3", start, exp_start);
    @(negedge clk);
    check("R11 pulse one clock", start, 0);
    check("R9 pwrdn after release", pwrdn, !exp_start);
  endtask

  // monitor: compares reads as they complete
  initial begin
    int rcnt = 0;
    logic [7:0] held = 8'h00;
    exp_t e;
    forever begin
      @(negedge clk);
      if (sel && rd && !wr) rcnt++;
      else rcnt = 0;
      if (rcnt == 2) begin
        if (sb.size() == 0) check("R6 unexpected read", 0, 1);
        else begin
          e = sb.pop_front();
          check(e.tag, dout, e.val);
          held = dout;
        end
      end else if (rcnt == 3) begin
        check("R6 read data held", dout, held);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (start) pulses++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    check("R7 pwrdn at start", pwrdn, 1);
    check("R7 start at start", start, 0);
    check("R7 dout at start", dout, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1, R2, R6
    hwr(2'b00, 8'h02);
    hwr(2'b01, 8'h11); hwr(2'b01, 8'h22); hwr(2'b01, 8'h33);
    hrd(2'b00, 8'h02, "R1 address readback");
    hwr(2'b00, 8'h02);
    hrd(2'b01, 8'h11, "R2 reg2");
    hrd(2'b01, 8'h22, "R2 R6 reg3 single step");
    hrd(2'b01, 8'h33, "R2 reg4");
    hwr(2'b00, 8'h0F);
    hwr(2'b01, 8'h81); hwr(2'b01, 8'h40);
    hwr(2'b00, 8'h0F);
    hrd(2'b01, 8'h81, "R2 last reg");
    hrd(2'b01, 8'h40, "R2 wrap to reg0");

    // R3 table bytes R,G,B then next entry
    hwr(2'b00, 8'h03);
    hwr(2'b10, 8'hA1); hwr(2'b10, 8'hA2); hwr(2'b10, 8'hA3);
    hwr(2'b10, 8'hB1); hwr(2'b10, 8'hB2); hwr(2'b10, 8'hB3);
    hwr(2'b00, 8'h03);
    hrd(2'b10, 8'hA1, "R3 e3 red");
    hrd(2'b10, 8'hA2, "R3 e3 green");
    hrd(2'b10, 8'hA3, "R3 e3 blue");
    hrd(2'b10, 8'hB1, "R3 e4 red");
    hrd(2'b10, 8'hB2, "R3 e4 green");
    hrd(2'b10, 8'hB3, "R3 e4 blue");

    // R4 new address resets byte position
    hwr(2'b00, 8'h03); hwr(2'b10, 8'h77);
    hwr(2'b00, 8'h04);
    hrd(2'b10, 8'hB1, "R4 reload gives red");
    hwr(2'b00, 8'h03);
    hrd(2'b10, 8'h77, "R4 red rewritten");
    hrd(2'b10, 8'hA2, "R4 green untouched");

    // R3 table wrap
    hwr(2'b00, 8'h0F);
    hwr(2'b10, 8'hC1); hwr(2'b10, 8'hC2); hwr(2'b10, 8'hC3);
    hwr(2'b10, 8'hD1); hwr(2'b10, 8'hD2); hwr(2'b10, 8'hD3);
    hwr(2'b00, 8'h00);
    hrd(2'b10, 8'hD1, "R3 wrap e0 red");
    hrd(2'b10, 8'hD2, "R3 wrap e0 green");
    hrd(2'b10, 8'hD3, "R3 wrap e0 blue");
    hwr(2'b00, 8'h0F);
    hrd(2'b10, 8'hC1, "R3 e15 red");

    // R5 reserved select
    hwr(2'b00, 8'h02);
    hwr(2'b11, 8'hFF);
    hrd(2'b11, 8'h00, "R5 reserved reads zero");
    hrd(2'b01, 8'h11, "R5 index untouched");

    // R12 extended configuration gate
    hwr(2'b00, 8'h0E); hwr(2'b01, 8'h15); hwr(2'b01, 8'h3C);
    @(negedge clk);
    check("R12 gate closed", ext, 15'h0000);
    hwr(2'b00, 8'h0E); hwr(2'b01, 8'h95);
    @(negedge clk);
    check("R12 gate open", ext, {8'h3C, 7'h15});

    // R10 software start
    check("R10 idle before run bit", pwrdn, 1);
    p0 = pulses;
    hwr(2'b00, 8'h00); hwr(2'b01, 8'h41);
    settle();
    check("R10 one pulse on run bit", pulses, p0 + 1);
    check("R10 powered up", pwrdn, 0);
    hwr(2'b00, 8'h00); hwr(2'b01, 8'h41);
    settle();
    check("R10 no pulse on rewrite", pulses, p0 + 1);
    hwr(2'b00, 8'h00);
    hrd(2'b01, 8'h41, "R10 run bit readback");
    hwr(2'b00, 8'h00); hwr(2'b01, 8'h40);
    settle();
    check("R10 cleared run bit powers down", pwrdn, 1);
    check("R10 no pulse on clear", pulses, p0 + 1);

    // R8 retention while powered down
    hwr(2'b00, 8'h02);
    hrd(2'b01, 8'h11, "R8 reg kept in power-down");
    hwr(2'b00, 8'h04);
    hrd(2'b10, 8'hB1, "R8 table kept in power-down");

    // R9 hardware start; run bit ignored
    p0 = pulses;
    hwr(2'b00, 8'h00); hwr(2'b01, 8'h43);
    settle();
    check("R9 run bit ignored in hw mode", pulses, p0);
    check("R9 still powered down", pwrdn, 1);
    do_reset(1'b1);
    hrd(2'b00, 8'h00, "R7 address cleared by reset");
    hrd(2'b01, 8'h42, "R8 reg kept, run bit cleared");
    hrd(2'b10, 8'hD1, "R8 table kept across reset");
    p0 = pulses;
    hwr(2'b00, 8'h00); hwr(2'b01, 8'h42);
    settle();
    check("R9 clearing run bit ignored", pwrdn, 0);
    hwr(2'b00, 8'h00); hwr(2'b01, 8'h43);
    settle();
    check("R9 setting run bit ignored", pulses, p0);

    // back to software mode, reset gives no start
    hwr(2'b00, 8'h00); hwr(2'b01, 8'h40);
    do_reset(1'b0);
    check("R10 idle after reset in sw mode", pwrdn, 1);

    repeat (4) @(negedge clk);
    check("R6 scoreboard drained", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule